// File: doc/BRIEF.md
# Duty-Queued Pulse-Width Modulator

This block produces a single pulse-width modulated output whose duty values are not written straight into the comparator. Software pushes duty samples through a small register port into a queue, and the modulator takes one sample from the head of that queue at each period boundary. A sample written while the queue is empty still waits for the next boundary. Lowering the duty in the middle of a period therefore never cuts the running period short, and it can never stretch that period into one that is high from start to end.

Software sets the period length, starts and stops the modulator, and reads the running counter to see how far the current period has advanced. It can also read the active sample and a status word with the queue occupancy, a sticky overflow flag and a watermark flag. When the queue runs dry the last sample stays in force, so the waveform repeats until new samples arrive.

Top module: `duty_queue_pwm`

## Requirements
- R1: The queue holds up to DEPTH (default 4) samples. Status register (address 4) bits [15:8] report the number of queued samples.
- R2: A sample write that finds the queue full, with no sample leaving the queue in the same cycle, is dropped and sets status bit 0. The flag stays set until software writes status with bit 0 at 1. A status write with bit 0 at 0 leaves the flag unchanged.
- R3: While enabled, the counter steps by one each cycle from 0 up to the period register (address 2), then returns to 0, so a period lasts period+1 cycles. The counter value is readable at address 3.
- R4: A queued sample becomes active only on the clock edge at which the counter is at or above the period value. This holds even for a write to an empty queue. One sample is consumed per period boundary.
- R5: If the queue is empty at a period boundary, the active sample is kept unchanged.
- R6: The output is high in the cycle after each cycle whose counter value is below the active sample. Each period is therefore high for min(sample, period+1) cycles: a sample of 0 keeps the output low, and a sample above the period keeps it high.
- R7: Control bit 0 (address 0) enables the block. While it is 0, the counter is held at 0, the output is low, the queue is empty and sample writes are discarded.
- R8: Control bit 1 (stop enable) and bits [5:4] (watermark) read back as written. Status bit 1 is 1 whenever the occupancy is less than or equal to the watermark.
- R9: Read data appears on the edge after the address is presented. Address 1 reads the active sample, and register writes take effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address (0 control, 1 sample, 2 period, 3 counter, 4 status) |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| pwm_out | output | 1 | Registered modulated output |

## Verification
The output is registered, so it follows each counter value one cycle later. Read data follows its address by one edge. A queued sample becomes active on the edge on which the counter is at its limit, and every register write counts from the edge that captures it. The bench keeps a cycle-level model, updated on rising edges from the inputs it drove on falling edges, and compares the output against that model on every falling edge. Register reads are compared against a snapshot of the model taken when the address was presented. A sweep lowers the duty at every counter position and checks that the longest high run stays equal to the old sample.

// File: rtl/duty_queue_pwm_pkg.sv
package duty_queue_pwm_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_SAMPLE = 3'd1;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;
  // control fields
  localparam int C_EN   = 0;
  localparam int C_STOP = 1;
  localparam int C_WM   = 4;
  localparam int WM_W   = 2;
  // status fields
  localparam int S_OVF  = 0;
  localparam int S_ROOM = 1;
  localparam int S_OCC  = 8;
endpackage

// File: rtl/duty_queue_pwm_fifo.sv
module duty_queue_pwm_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flush,
  input  logic           push_req,
  input  logic [DW-1:0]  push_data,
  input  logic           pop,
  output logic [DW-1:0]  head_data,
  output logic           head_valid,
  output logic [OCW-1:0] occ,
  output logic           drop
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          accept;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    accept = push_req && ((occ != OCW'(DEPTH)) || pop);
    drop   = push_req && !accept;
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (accept) wptr <= step(wptr);
      if (pop)    rptr <= step(rptr);
      occ <= occ + OCW'(accept) - OCW'(pop);
    end
  end

  assign head_data  = mem[rptr];
  assign head_valid = (occ != '0);
endmodule

// File: rtl/duty_queue_pwm_regs.sv
module duty_queue_pwm_regs
  import duty_queue_pwm_pkg::*;
#(
  parameter int RW  = 32,
  parameter int CW  = 16,
  parameter int OCW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [RW-1:0]     wdata,
  input  logic              drop,
  input  logic [CW-1:0]     cnt,
  input  logic [CW-1:0]     act,
  input  logic [OCW-1:0]    occ,
  output logic              en,
  output logic [CW-1:0]     period,
  output logic              push_req,
  output logic [RW-1:0]     rdata
);
  logic            stop_en;
  logic [WM_W-1:0] wm;
  logic            ovf;
  logic            room;
  logic [RW-1:0]   rd_mux;

  always_comb begin
    push_req = wr && (addr == A_SAMPLE) && en;
    room     = (RW'(occ) <= RW'(wm));
    rd_mux   = '0;
    case (addr)
      A_CTRL: begin
        rd_mux[C_EN]            = en;
        rd_mux[C_STOP]          = stop_en;
        rd_mux[C_WM +: WM_W]    = wm;
      end
      A_SAMPLE: rd_mux[CW-1:0]  = act;
      A_PERIOD: rd_mux[CW-1:0]  = period;
      A_COUNT:  rd_mux[CW-1:0]  = cnt;
      A_STATUS: begin
        rd_mux[S_OVF]           = ovf;
        rd_mux[S_ROOM]          = room;
        rd_mux[S_OCC +: OCW]    = occ;
      end
      default:  rd_mux          = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en      <= 1'b0;
      stop_en <= 1'b0;
      wm      <= '0;
      period  <= '0;
      ovf     <= 1'b0;
      rdata   <= '0;
    end else begin
      if (wr && addr == A_CTRL) begin
        en      <= wdata[C_EN];
        stop_en <= wdata[C_STOP];
        wm      <= wdata[C_WM +: WM_W];
      end
      if (wr && addr == A_PERIOD) period <= wdata[CW-1:0];
      if (drop) ovf <= 1'b1;
      else if (wr && addr == A_STATUS && wdata[S_OVF]) ovf <= 1'b0;
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/duty_queue_pwm_core.sv
module duty_queue_pwm_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] period,
  input  logic [CW-1:0] head_data,
  input  logic          head_valid,
  output logic          pop,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] act,
  output logic          pwm_out
);
  logic wrap;

  always_comb begin
    wrap = (cnt >= period);
    pop  = en && wrap && head_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act     <= '0;
      pwm_out <= 1'b0;
    end else if (!en) begin
      cnt     <= '0;
      pwm_out <= 1'b0;
    end else begin
      pwm_out <= (cnt < act);
      if (wrap) begin
        cnt <= '0;
        if (head_valid) act <= head_data;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/duty_queue_pwm.sv
module duty_queue_pwm
  import duty_queue_pwm_pkg::*;
#(
  parameter int RW    = 32,
  parameter int CW    = 16,
  parameter int DEPTH = 4,
  localparam int OCW  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          pwm_out
);
  logic           en;
  logic [CW-1:0]  period, cnt, act, head_data;
  logic           head_valid, pop, push_req, drop;
  logic [OCW-1:0] occ;
  logic [RW-1:0]  rdata_w;

  duty_queue_pwm_regs #(.RW(RW), .CW(CW), .OCW(OCW)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(RW'(reg_wdata)),
    .drop(drop), .cnt(cnt), .act(act), .occ(occ),
    .en(en), .period(period), .push_req(push_req), .rdata(rdata_w)
  );

  duty_queue_pwm_fifo #(.DW(CW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(!en), .push_req(push_req),
    .push_data(reg_wdata[CW-1:0]), .pop(pop),
    .head_data(head_data), .head_valid(head_valid), .occ(occ), .drop(drop)
  );

  duty_queue_pwm_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .en(en), .period(period),
    .head_data(head_data), .head_valid(head_valid),
    .pop(pop), .cnt(cnt), .act(act), .pwm_out(pwm_out)
  );

  assign reg_rdata = 32'(rdata_w);
endmodule

// File: rtl/duty_queue_pwm_chk.sv
module duty_queue_pwm_chk #(
  parameter int CW    = 16,
  parameter int DEPTH = 4,
  parameter int OCW   = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  period,
  input logic [CW-1:0]  act,
  input logic [OCW-1:0] occ,
  input logic           pwm_out,
  input logic           reg_wr,
  input logic [2:0]     reg_addr,
  input logic [31:0]    reg_wdata,
  input logic [31:0]    reg_rdata
);
  // R1: occupancy never exceeds the queue depth
  a_r1_occ_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= OCW'(DEPTH));

  // R3: counter returns to zero after reaching the limit
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (en && cnt >= period) |=> (cnt == '0));

  // R3: counter steps by one below the limit
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (en && cnt < period) |=> (!en || cnt == $past(cnt) + 1'b1));

  // R4: the active sample changes only at a period boundary
  a_r4_load_at_wrap: assert property (@(posedge clk) disable iff (rst)
    !$stable(act) |-> $past(en && cnt >= period));

  // R7: disabled means low output and empty queue on the next cycle
  a_r7_off_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwm_out && occ == '0 && cnt == '0));

  // R2: the overflow flag survives anything but a write-one clear
  a_r2_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 3'd4 && !reg_wr) ##1 (reg_rdata[0] && reg_addr == 3'd4 && !(reg_wr && reg_wdata[0]))
      |=> reg_rdata[0]);
endmodule

bind duty_queue_pwm duty_queue_pwm_chk #(.CW(CW), .DEPTH(DEPTH), .OCW(OCW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .cnt(cnt), .period(period), .act(act),
  .occ(occ), .pwm_out(pwm_out), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/duty_queue_pwm_bench.sv
module duty_queue_pwm_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_out;

  duty_queue_pwm u_duty_queue_pwm (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0, chk_on = 0;

  // cycle-level model built from the requirements
  bit m_en, m_stop, m_ovf, m_out, m_pop, m_push, m_acc, m_nxt;
  int m_wm, m_per, m_cnt, m_act, m_qn;
  int q [4];
  int snap_cnt, snap_act, snap_qn, snap_status;

  function automatic int status_word();
    return (m_ovf ? 1 : 0) | ((m_qn <= m_wm) ? 2 : 0) | (m_qn << 8);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_stop = 0; m_ovf = 0; m_out = 0;
      m_wm = 0; m_per = 0; m_cnt = 0; m_act = 0; m_qn = 0;
    end else begin
      m_pop  = m_en && m_cnt >= m_per && m_qn > 0;
      m_push = reg_wr && reg_addr == 3'd1 && m_en;
      m_acc  = m_push && (m_qn < 4 || m_pop);
      m_nxt  = m_en && (m_cnt < m_act);
      if (!m_en) begin
        m_cnt = 0; m_qn = 0;
      end else if (m_cnt >= m_per) begin
        m_cnt = 0;
        if (m_qn > 0) begin
          m_act = q[0];
          for (int i = 0; i < 3; i++) q[i] = q[i+1];
          m_qn--;
        end
      end else m_cnt++;
      if (m_acc) begin q[m_qn] = int'(reg_wdata[15:0]); m_qn++; end
      if (m_push && !m_acc) m_ovf = 1;
      else if (reg_wr && reg_addr == 3'd4 && reg_wdata[0]) m_ovf = 0;
      if (reg_wr && reg_addr == 3'd0) begin
        m_en = reg_wdata[0]; m_stop = reg_wdata[1]; m_wm = int'(reg_wdata[5:4]);
      end
      if (reg_wr && reg_addr == 3'd2) m_per = int'(reg_wdata[15:0]);
      m_out = m_nxt;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle output comparison (R4, R6, R7)
  int run = 0, max_run = 0;
  bit clr_run = 0;
  always @(negedge clk) begin
    if (chk_on) chk("R6 output per cycle", int'(pwm_out), int'(m_out));
    if (clr_run) begin run = 0; max_run = 0; end
    else begin
      run = pwm_out ? run + 1 : 0;
      if (run > max_run) max_run = run;
    end
  end

  task automatic wr(input logic [2:0] a, input int d);
    reg_addr = a; reg_wdata = 32'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    snap_cnt = m_cnt; snap_act = m_act; snap_qn = m_qn; snap_status = status_word();
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk_on = 1;
    rd(3'd0, v); chk("R7 reset control", v, 0);
    rd(3'd4, v); chk("R1 reset status", v, 32'h2);
    rd(3'd3, v); chk("R3 reset counter", v, 0);
    chk("R6 reset output", int'(pwm_out), 0);

    wr(3'd0, 32'h22);
    rd(3'd0, v); chk("R8 control readback", v, 32'h22);
    wr(3'd1, 9);
    rd(3'd4, v); chk("R7 write while disabled discarded", v, 32'h2);

    wr(3'd2, 200);
    wr(3'd0, 32'h23);
    for (int i = 0; i < 5; i++) wr(3'd1, 10 + i);
    rd(3'd4, v); chk("R2 overflow and R1 occupancy", v, 32'h401);
    rd(3'd1, v); chk("R9 active before boundary", v, 0);
    wr(3'd4, 0);
    rd(3'd4, v); chk("R2 write zero keeps flag", v, 32'h401);
    wr(3'd4, 1);
    rd(3'd4, v); chk("R2 write one clears flag", v, 32'h400);
    rd(3'd3, v); chk("R3 counter readback", v, snap_cnt);

    while (m_cnt != 200) @(negedge clk);
    idle(2);
    rd(3'd1, v); chk("R4 first sample at boundary", v, 10);
    rd(3'd4, v); chk("R1 occupancy after one pop", v, 32'h300);
    idle(201 * 5);
    rd(3'd1, v); chk("R5 last sample retained", v, 13);
    rd(3'd4, v); chk("R8 room flag when drained", v, 32'h2);
    wr(3'd2, 3);
    idle(8);
    rd(3'd3, v); chk("R3 shortened period counter", v, snap_cnt);

    wr(3'd1, 5); wr(3'd1, 6);
    wr(3'd0, 32'h20);
    idle(2);
    rd(3'd3, v); chk("R7 counter held at zero", v, 0);
    rd(3'd4, v); chk("R7 queue flushed", v, 32'h2);
    idle(6);
    chk("R7 output low when off", int'(pwm_out), 0);

    // sweep: lower the duty at every counter position
    wr(3'd2, 7);
    wr(3'd0, 32'h01);
    for (int s1 = 1; s1 <= 9; s1++) begin
      for (int s2 = 0; s2 < s1; s2++) begin
        for (int k = 0; k <= 7; k++) begin
          wr(3'd1, s1);
          idle(18);
          clr_run = 1; @(negedge clk); clr_run = 0;
          idle(8);
          while (m_cnt != k) @(negedge clk);
          wr(3'd1, s2);
          rd(3'd1, v); chk("R4 old sample still active", v, s1);
          idle(18);
          rd(3'd1, v); chk("R4 new sample after boundary", v, s2);
          if (s1 <= 7) chk("R4 no full-high period", max_run, s1);
        end
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    chk_on = 0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule